// File: doc/BRIEF.md
# Processor Bus Write-Burst Tracker

This block sits on the slave side of a processor bus that carries addresses and data on the same wires. Each cycle in which the command strobe is high, it reads a 5-bit command word. Bit 4 tells whether the word describes a transaction (an address cycle) or a data beat. The same lower bits then mean different things. In an address cycle they give direction, single or block transfer, and size. In a data cycle bit 3 is an active-low end-of-data marker.

Accepted address cycles produce a one-cycle decoded transaction pulse. Write data beats produce a one-cycle data strobe together with a last-beat flag. Behind these pulses is a three-state machine (idle, burst open, last beat) that moves on the end-of-data marker and does not count beats. A single-word write closes on its only beat.

The block drives an active-low write-ready output, which a bus master must see low before it starts a write. It raises two sticky error flags. One is for a write started against write-ready. The other is for a command that is not defined in the current state.

Top module: `wbt_tracker`

## Requirements
- R1: Synchronous active-high reset leaves the machine idle. Afterwards both error flags are 0, txn_valid and wdata_valid are 0, and wr_rdy_n is low while wbuf_full is low.
- R2: An accepted address cycle (cmd[4]=0) is decoded as follows: cmd[3] is the direction (1 = write), cmd[2] is the transfer type (1 = block) and cmd[1:0] is the size. The cycle after the sample, txn_valid pulses for one cycle. txn_write, txn_block and txn_size show the decoded fields and hold them until the next accepted address.
- R3: A data cycle (cmd[4]=1) inside an open write makes wdata_valid pulse for one cycle, in the cycle after the sample. In that cycle wdata_last equals the inverse of cmd[3]. cmd[2:0] of a data cycle has no effect on any output.
- R4: A block write (address code 5'b01111) accepts any number of beats from 1 to 8 and ends only on the beat with cmd[3]=0. Idle cycles between beats produce no strobe.
- R5: A single write (cmd[2]=0 in its address) ends on its first data beat, which reports wdata_last=1 even when cmd[3]=1.
- R6: wr_rdy_n is high from the cycle after an accepted write address through the cycle in which the final beat's strobe appears. It is low in the next cycle. It is also high in any cycle in which wbuf_full is high.
- R7: A write address cycle sampled while wr_rdy_n is high is not accepted: no txn_valid and no change to an open burst. It sets err_busy from the next cycle, and err_busy stays set until reset.
- R8: Three commands are reserved: a block address with size other than 2'b11, a data cycle while no write is open, and a read address while a write burst is open. A reserved command sets err_reserved (sticky until reset), produces no pulse, and leaves an open burst running.
- R9: A read address (cmd[3]=0) sampled while no burst is open is accepted, with txn_write=0, and wr_rdy_n is unaffected.
- R10: While cmd_valid is low, cmd has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word is valid this cycle |
| cmd | input | 5 | Command word |
| wbuf_full | input | 1 | Internal write buffer is full |
| txn_valid | output | 1 | One-cycle pulse: address cycle accepted |
| txn_write | output | 1 | Decoded direction, 1 = write |
| txn_block | output | 1 | Decoded transfer type, 1 = block |
| txn_size | output | 2 | Decoded transfer size |
| wdata_valid | output | 1 | One-cycle pulse: write data beat accepted |
| wdata_last | output | 1 | Beat reported with wdata_valid is the final one |
| wr_rdy_n | output | 1 | Active-low write-ready |
| err_busy | output | 1 | Sticky: write started while write-ready was high |
| err_reserved | output | 1 | Sticky: reserved command seen |

## Verification
The hardest case to reach is a write address that arrives in the single cycle when the machine sits in its last-beat state. In that cycle wr_rdy_n is still high although the burst has already ended. The bench issues that address on the cycle straight after a final beat. It then checks that the address is refused, that err_busy sets, and that write-ready falls one cycle later. A read address inside an open burst, and a data beat with no write open, are reached by the same back-to-back stimulus within the scenario tasks.

// File: rtl/wbt_pkg.sv
package wbt_pkg;
    localparam int CMD_W  = 5;
    localparam int SIZE_W = 2;
    localparam int B_KIND = 4;
    localparam int B_DIR  = 3;
    localparam int B_ATTR = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_LAST  = 2'd2
    } wbt_state_e;

    typedef struct packed {
        logic              is_data;
        logic              dir_wr;
        logic              block;
        logic              more;
        logic [SIZE_W-1:0] size;
    } wbt_dec_t;

    typedef struct packed {
        wbt_state_e        state;
        logic              single;
        logic              txn_valid;
        logic              txn_write;
        logic              txn_block;
        logic [SIZE_W-1:0] txn_size;
        logic              wvalid;
        logic              wlast;
        logic              err_busy;
        logic              err_res;
    } wbt_regs_t;
endpackage

// File: rtl/wbt_decode.sv
module wbt_decode
    import wbt_pkg::*;
(
    input  logic [CMD_W-1:0] cmd,
    output wbt_dec_t         dec
);
    always_comb begin
        dec.is_data = cmd[B_KIND];
        // bit 3: direction in address cycles, active-low end marker in data cycles
        dec.dir_wr  = cmd[B_DIR] & ~cmd[B_KIND];
        dec.more    = cmd[B_DIR] &  cmd[B_KIND];
        dec.block   = cmd[B_ATTR];
        dec.size    = cmd[SIZE_W-1:0];
    end
endmodule

// File: rtl/wbt_ctrl.sv
module wbt_ctrl
    import wbt_pkg::*;
#(
    parameter logic [SIZE_W-1:0] BLOCK_SIZE = '1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      cmd_valid,
    input  wbt_dec_t  dec,
    input  logic      wbuf_full,
    output wbt_regs_t regs,
    output logic      wr_rdy_n
);
    localparam wbt_regs_t RST_VAL = '{state: ST_IDLE, txn_size: '0, default: 1'b0};

    wbt_regs_t r_d, r_q;
    logic      busy;

    always_comb begin
        busy = (r_q.state != ST_IDLE) || wbuf_full;
        r_d           = r_q;
        r_d.txn_valid = 1'b0;
        r_d.wvalid    = 1'b0;
        r_d.wlast     = 1'b0;
        if (r_q.state == ST_LAST) begin
            r_d.state = ST_IDLE;
        end
        if (cmd_valid) begin
            if (!dec.is_data) begin
                if (dec.dir_wr) begin
                    if (busy) begin
                        r_d.err_busy = 1'b1;
                    end else if (dec.block && dec.size != BLOCK_SIZE) begin
                        r_d.err_res = 1'b1;
                    end else begin
                        r_d.txn_valid = 1'b1;
                        r_d.txn_write = 1'b1;
                        r_d.txn_block = dec.block;
                        r_d.txn_size  = dec.size;
                        r_d.single    = ~dec.block;
                        r_d.state     = ST_BURST;
                    end
                end else if (r_q.state == ST_BURST) begin
                    r_d.err_res = 1'b1;
                end else begin
                    r_d.txn_valid = 1'b1;
                    r_d.txn_write = 1'b0;
                    r_d.txn_block = dec.block;
                    r_d.txn_size  = dec.size;
                end
            end else if (r_q.state == ST_BURST) begin
                r_d.wvalid = 1'b1;
                r_d.wlast  = r_q.single | ~dec.more;
                if (r_q.single || !dec.more) begin
                    r_d.state = ST_LAST;
                end
            end else begin
                r_d.err_res = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= RST_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    assign regs     = r_q;
    assign wr_rdy_n = busy;
endmodule

// File: rtl/wbt_tracker.sv
module wbt_tracker
    import wbt_pkg::*;
#(
    parameter logic [SIZE_W-1:0] BLOCK_SIZE = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd,
    input  logic              wbuf_full,
    output logic              txn_valid,
    output logic              txn_write,
    output logic              txn_block,
    output logic [SIZE_W-1:0] txn_size,
    output logic              wdata_valid,
    output logic              wdata_last,
    output logic              wr_rdy_n,
    output logic              err_busy,
    output logic              err_reserved
);
    wbt_dec_t  dec;
    wbt_regs_t regs;

    wbt_decode u_dec (
        .cmd (cmd),
        .dec (dec)
    );

    wbt_ctrl #(.BLOCK_SIZE(BLOCK_SIZE)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .dec       (dec),
        .wbuf_full (wbuf_full),
        .regs      (regs),
        .wr_rdy_n  (wr_rdy_n)
    );

    assign txn_valid    = regs.txn_valid;
    assign txn_write    = regs.txn_write;
    assign txn_block    = regs.txn_block;
    assign txn_size     = regs.txn_size;
    assign wdata_valid  = regs.wvalid;
    assign wdata_last   = regs.wlast;
    assign err_busy     = regs.err_busy;
    assign err_reserved = regs.err_res;
endmodule

// File: rtl/wbt_checker.sv
module wbt_checker (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic [4:0] cmd,
    input logic       wbuf_full,
    input logic       txn_valid,
    input logic       txn_write,
    input logic       wdata_valid,
    input logic       wdata_last,
    input logic       wr_rdy_n,
    input logic       err_busy,
    input logic       err_reserved
);
    a_r2_txn_from_addr: assert property (@(posedge clk) disable iff (rst)
        txn_valid |-> $past(cmd_valid && !cmd[4]));
    a_r3_beat_from_data: assert property (@(posedge clk) disable iff (rst)
        wdata_valid |-> $past(cmd_valid && cmd[4]));
    a_r6_rdy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && txn_write) |-> wr_rdy_n);
    a_r6_release: assert property (@(posedge clk) disable iff (rst)
        (wdata_valid && wdata_last) |=> (wr_rdy_n == wbuf_full));
    a_r6_full_blocks: assert property (@(posedge clk) disable iff (rst)
        wbuf_full |-> wr_rdy_n);
    a_r7_busy_flag: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd[4] && cmd[3] && wr_rdy_n) |=> (err_busy && !txn_valid));
    a_r7_busy_sticky: assert property (@(posedge clk) disable iff (rst)
        err_busy |=> err_busy);
    a_r8_reserved_sticky: assert property (@(posedge clk) disable iff (rst)
        err_reserved |=> err_reserved);
endmodule

bind wbt_tracker wbt_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .cmd_valid    (cmd_valid),
    .cmd          (cmd),
    .wbuf_full    (wbuf_full),
    .txn_valid    (txn_valid),
    .txn_write    (txn_write),
    .wdata_valid  (wdata_valid),
    .wdata_last   (wdata_last),
    .wr_rdy_n     (wr_rdy_n),
    .err_busy     (err_busy),
    .err_reserved (err_reserved)
);

// File: tb/sim_wbt_tracker.sv
module sim_wbt_tracker;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [4:0] cmd = '0;
    logic       wbuf_full = 1'b0;
    logic       txn_valid, txn_write, txn_block, wdata_valid, wdata_last;
    logic       wr_rdy_n, err_busy, err_reserved;
    logic [1:0] txn_size;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wbt_tracker u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd), .wbuf_full(wbuf_full),
        .txn_valid(txn_valid), .txn_write(txn_write), .txn_block(txn_block),
        .txn_size(txn_size), .wdata_valid(wdata_valid), .wdata_last(wdata_last),
        .wr_rdy_n(wr_rdy_n), .err_busy(err_busy), .err_reserved(err_reserved)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [4:0] c);
        @(negedge clk);
        cmd_valid = v;
        cmd = c;
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cmd_valid = 1'b0; wbuf_full = 1'b0;
        @(posedge clk); #2;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        chk("R1 txn_valid", {7'd0, txn_valid}, 8'd0);
        chk("R1 wdata_valid", {7'd0, wdata_valid}, 8'd0);
        chk("R1 errors", {6'd0, err_busy, err_reserved}, 8'd0);
        chk("R1 wr_rdy_n", {7'd0, wr_rdy_n}, 8'd0);
    endtask

    task automatic t_block(input int n, input bit gaps);
        do_reset();
        step(1'b1, 5'b01111);
        chk("R2 block write decode", {3'd0, txn_valid, txn_write, txn_block, txn_size}, 8'h1F);
        chk("R6 rdy high after accept", {7'd0, wr_rdy_n}, 8'd1);
        for (int i = 0; i < n; i++) begin
            logic more;
            more = (i != n - 1);
            step(1'b1, {1'b1, more, 3'(i)});
            chk("R4 beat strobe", {6'd0, wdata_valid, wdata_last}, {6'd0, 1'b1, ~more});
            chk("R6 rdy high in burst", {7'd0, wr_rdy_n}, 8'd1);
            if (gaps && more) begin
                step(1'b0, 5'b10000);
                chk("R3 no strobe in gap", {7'd0, wdata_valid}, 8'd0);
            end
        end
        step(1'b0, 5'b00000);
        chk("R6 rdy released", {6'd0, wr_rdy_n, wdata_valid}, 8'd0);
        chk("R4 held txn fields", {3'd0, txn_valid, txn_write, txn_block, txn_size}, 8'h0F);
    endtask

    task automatic t_single();
        do_reset();
        step(1'b1, 5'b01010);
        chk("R2 single write decode", {3'd0, txn_valid, txn_write, txn_block, txn_size}, 8'h1A);
        step(1'b1, 5'b11111);
        chk("R5 single beat is last", {6'd0, wdata_valid, wdata_last}, 8'd3);
        step(1'b0, 5'b0);
        chk("R5 single closed", {7'd0, wr_rdy_n}, 8'd0);
        step(1'b1, 5'b11000);
        chk("R8 beat after close reserved", {6'd0, wdata_valid, err_reserved}, 8'd1);
    endtask

    task automatic t_busy_last();
        do_reset();
        step(1'b1, 5'b01111);
        step(1'b1, 5'b10000);
        chk("R6 rdy high on last strobe", {6'd0, wdata_last, wr_rdy_n}, 8'd3);
        step(1'b1, 5'b01010);
        chk("R7 write in last cycle refused", {6'd0, txn_valid, err_busy}, 8'd1);
        chk("R6 rdy low after last", {7'd0, wr_rdy_n}, 8'd0);
        step(1'b0, 5'b0);
        chk("R7 busy sticky", {7'd0, err_busy}, 8'd1);
    endtask

    task automatic t_wbuf();
        do_reset();
        wbuf_full = 1'b1;
        #1;
        chk("R6 rdy high when buffer full", {7'd0, wr_rdy_n}, 8'd1);
        step(1'b1, 5'b01011);
        chk("R7 write refused when full", {6'd0, txn_valid, err_busy}, 8'd1);
        wbuf_full = 1'b0;
        #1;
        chk("R6 rdy low when buffer drains", {7'd0, wr_rdy_n}, 8'd0);
        step(1'b1, 5'b10000);
        chk("R7 refused write left no burst", {6'd0, wdata_valid, err_reserved}, 8'd1);
    endtask

    task automatic t_reserved();
        do_reset();
        step(1'b1, 5'b01101);
        chk("R8 bad block size", {5'd0, txn_valid, err_reserved, wr_rdy_n}, 8'd2);
        do_reset();
        step(1'b1, 5'b01111);
        step(1'b1, 5'b00011);
        chk("R8 read in burst", {6'd0, txn_valid, err_reserved}, 8'd1);
        chk("R8 burst still open", {7'd0, wr_rdy_n}, 8'd1);
        step(1'b1, 5'b10111);
        chk("R8 burst continues", {6'd0, wdata_valid, wdata_last}, 8'd3);
        chk("R3 bits 2..0 ignored", {7'd0, err_busy}, 8'd0);
    endtask

    task automatic t_read();
        do_reset();
        step(1'b1, 5'b00001);
        chk("R9 single read", {3'd0, txn_valid, txn_write, txn_block, txn_size}, 8'h11);
        chk("R9 rdy unaffected", {6'd0, wr_rdy_n, err_reserved}, 8'd0);
        step(1'b1, 5'b00111);
        chk("R9 block read", {3'd0, txn_valid, txn_write, txn_block, txn_size}, 8'h17);
        step(1'b0, 5'b0);
        chk("R2 pulse one cycle", {7'd0, txn_valid}, 8'd0);
    endtask

    task automatic t_ignore_invalid();
        do_reset();
        step(1'b0, 5'b01111);
        chk("R10 invalid address ignored", {6'd0, txn_valid, wr_rdy_n}, 8'd0);
        step(1'b1, 5'b01111);
        step(1'b0, 5'b10000);
        chk("R10 invalid beat ignored", {6'd0, wdata_valid, wr_rdy_n}, 8'd1);
        chk("R10 no error", {6'd0, err_busy, err_reserved}, 8'd0);
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_block(1, 1'b0);
        t_block(3, 1'b1);
        t_block(8, 1'b0);
        t_single();
        t_busy_last();
        t_wbuf();
        t_reserved();
        t_read();
        t_ignore_invalid();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule